// File: doc/BRIEF.md
# Lockable Watchdog Timer with Trip Counter

This block is a watchdog timer driven through a small register bus. A countdown register is reloaded from a programmable period value. The countdown only advances on cycles where the external tick-enable input is high. Each time the countdown runs out, the block reloads it and raises a sticky expiration flag. When a programmable number of expirations has been tolerated, the next one asserts a system-reset output, and that output stays asserted until the external reset input is applied.

The configuration registers are protected by a key. Writes to the control, period and trip registers only take effect after the key word has been written to the unlock register. Any write to the lock register protects them again. A write attempted while locked is dropped and raises a sticky violation flag. Software keeps the timer alive by unlocking and then writing any value to the period register. Once the timer is running, that write only reloads the countdown and no longer changes the period. The intended start order is: unlock, set the trip value, set the period, enable, lock.

The bus is a plain single-cycle register port. Writes are accepted on every clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. There is no back-pressure.

Top module: `wdog_guard`

Register addresses: 0 control (bit 0 = enable), 1 period, 2 current count (read only), 3 trip, 4 unlock, 5 lock, 6 status, 7 expiration count (read only). The status read layout is: bit 0 expired, bit 1 violation, bit 2 reset asserted, bit 3 locked, bit 4 enabled.

## Requirements
- R1: After `rst_n` is low, the block is locked and disabled, with period 0, count 0, trip 0 and expiration count 0. `wdt_rst` is 0 and both status flags are 0, so a status read gives 0x08.
- R2: A write to control (0), period (1) or trip (3) while locked has no effect. It sets the violation flag (status bit 1, pin `sts_violation`).
- R3: Only the key 0xAD21AD21 written to address 4 unlocks the registers; any other value leaves them locked. Any write to address 5 locks them again.
- R4: While disabled and unlocked, a write to the period register sets the period and also loads the current count with the same value.
- R5: The current count changes only on cycles with `tick_en` high while enabled. On such a cycle, a count above 1 decreases by one.
- R6: On a tick while enabled with count of 1 or 0, the block has an expiration. The count reloads from the period, and the expired flag (status bit 0, pin `sts_expired`) is set and stays set.
- R7: While enabled, the period and trip values are frozen and writes to control are ignored. An unlocked write to the period only reloads the count from the stored period (service).
- R8: Status bits 0 and 1 clear when a 1 is written to that bit position at address 6. A write of 0 leaves them unchanged.
- R9: With trip value T, the first T expirations are only counted (readable at address 7). The expiration after that sets `wdt_rst`.
- R10: Once set, `wdt_rst` stays 1 and the count stops, whatever is done on the bus, until `rst_n` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, returns all state to defaults |
| tick_en | input | 1 | Watchdog tick, one count step per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| wdt_rst | output | 1 | System reset request, held once tripped |
| sts_expired | output | 1 | Sticky expiration flag |
| sts_violation | output | 1 | Sticky locked-write flag |

## Verification
The countdown is tried with `tick_en` held low, with single ticks, and with bursts of ticks. This separates counting on ticks from counting on clock edges, and the normal decrement from the reload at 1. Writes are issued in four states: locked, unlocked with a wrong key, unlocked while disabled, and unlocked while enabled. This shows whether protection, preload and service reload are each tied to the right state. A run of exactly T+1 expirations, with the reset output checked one tick before and one tick after the last one, pins the trip threshold to the exact expiration.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_W = 32;
  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'hAD21_AD21;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_PERIOD = 3'd1,
    A_COUNT  = 3'd2,
    A_TRIP   = 3'd3,
    A_UNLOCK = 3'd4,
    A_LOCK   = 3'd5,
    A_STATUS = 3'd6,
    A_EXPCNT = 3'd7
  } wd_addr_e;

  localparam int ST_EXPIRED = 0;
  localparam int ST_VIOL    = 1;
  localparam int ST_RST     = 2;
  localparam int ST_LOCKED  = 3;
  localparam int ST_EN      = 4;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TRIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              expire_i,
  output logic [CNT_W-1:0]  period_o,
  output logic [TRIP_W-1:0] trip_o,
  output logic              enabled_o,
  output logic              locked_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              expired_o,
  output logic              viol_o
);
  logic [CNT_W-1:0]  period_q;
  logic [TRIP_W-1:0] trip_q;
  logic              en_q, lock_q, exp_q, viol_q;
  logic              wr_cfg, wr_ok, wr_bad;

  always_comb begin
    wr_cfg = bus_wr && (bus_addr == A_CTRL || bus_addr == A_PERIOD || bus_addr == A_TRIP);
    wr_ok  = wr_cfg && !lock_q;
    wr_bad = wr_cfg && lock_q;
  end

  // a period write while unlocked either preloads (disabled) or services (enabled)
  assign load_o     = wr_ok && (bus_addr == A_PERIOD);
  assign load_val_o = en_q ? period_q : bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      trip_q   <= '0;
      en_q     <= 1'b0;
      lock_q   <= 1'b1;
      exp_q    <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_UNLOCK && bus_wdata == UNLOCK_KEY) lock_q <= 1'b0;
      if (bus_wr && bus_addr == A_LOCK) lock_q <= 1'b1;
      if (wr_ok && !en_q) begin
        case (bus_addr)
          A_CTRL:   en_q     <= bus_wdata[0];
          A_PERIOD: period_q <= bus_wdata[CNT_W-1:0];
          A_TRIP:   trip_q   <= bus_wdata[TRIP_W-1:0];
          default:  ;
        endcase
      end
      if (bus_wr && bus_addr == A_STATUS) begin
        if (bus_wdata[ST_EXPIRED]) exp_q  <= 1'b0;
        if (bus_wdata[ST_VIOL])    viol_q <= 1'b0;
      end
      if (expire_i) exp_q  <= 1'b1;
      if (wr_bad)   viol_q <= 1'b1;
    end
  end

  assign period_o  = period_q;
  assign trip_o    = trip_q;
  assign enabled_o = en_q;
  assign locked_o  = lock_q;
  assign expired_o = exp_q;
  assign viol_o    = viol_q;

  // R2: locked writes leave the configuration untouched
  a_r2_locked_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && lock_q) |=> ($stable(period_q) && $stable(trip_q) && $stable(en_q)));
  // R2: a locked config write raises the violation flag
  a_r2_viol_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && lock_q) |=> viol_q);
  // R7: configuration frozen while running
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(period_q) && $stable(trip_q) && en_q));
  // R3: a non-key write to unlock does not unlock
  a_r3_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !(bus_wr && bus_addr == A_UNLOCK && bus_wdata == UNLOCK_KEY)) |=> lock_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = run_i && tick_i && !load_i;
  assign expire_o = step && (cnt_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (expire_o)  cnt_q <= period_i;
    else if (step)      cnt_q <= cnt_q - ONE;
  end

  assign count_o = cnt_q;

  // R5: no tick and no load means the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(run_i && tick_i)) |=> $stable(cnt_q));
  // R5: a running tick above 1 decrements
  a_r5_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
  // R6: expiration reloads the period
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(period_i)));
endmodule

// File: rtl/wdog_trip.sv
module wdog_trip #(
  parameter int TRIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire_i,
  input  logic [TRIP_W-1:0] trip_i,
  output logic [TRIP_W-1:0] exp_cnt_o,
  output logic              rst_o
);
  logic [TRIP_W-1:0] ecnt_q;
  logic              rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      rst_q  <= 1'b0;
    end else if (expire_i && !rst_q) begin
      if (ecnt_q == trip_i) rst_q  <= 1'b1;
      else                  ecnt_q <= ecnt_q + 1'b1;
    end
  end

  assign exp_cnt_o = ecnt_q;
  assign rst_o     = rst_q;

  // R10: reset output, once set, is held
  a_r10_held: assert property (@(posedge clk) disable iff (!rst_n) rst_q |=> rst_q);
  // R9: tolerated count never passes the trip value
  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n) ecnt_q <= trip_i);
  // R9: reset only rises on an expiration
  a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(expire_i));
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TRIP_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst,
  output logic        sts_expired,
  output logic        sts_violation
);
  logic [CNT_W-1:0]  period, count, load_val;
  logic [TRIP_W-1:0] trip, exp_cnt;
  logic              enabled, locked, load, expire, trip_rst;

  wdog_regs #(.CNT_W(CNT_W), .TRIP_W(TRIP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expire_i(expire), .period_o(period), .trip_o(trip),
    .enabled_o(enabled), .locked_o(locked), .load_o(load), .load_val_o(load_val),
    .expired_o(sts_expired), .viol_o(sts_violation)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(enabled && !trip_rst), .tick_i(tick_en),
    .load_i(load && !trip_rst), .load_val_i(load_val), .period_i(period),
    .count_o(count), .expire_o(expire)
  );

  wdog_trip #(.TRIP_W(TRIP_W)) u_trip (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .trip_i(trip),
    .exp_cnt_o(exp_cnt), .rst_o(trip_rst)
  );

  assign wdt_rst = trip_rst;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata[0] = enabled;
      A_PERIOD: bus_rdata = 32'(period);
      A_COUNT:  bus_rdata = 32'(count);
      A_TRIP:   bus_rdata = 32'(trip);
      A_STATUS: begin
        bus_rdata[ST_EXPIRED] = sts_expired;
        bus_rdata[ST_VIOL]    = sts_violation;
        bus_rdata[ST_RST]     = trip_rst;
        bus_rdata[ST_LOCKED]  = locked;
        bus_rdata[ST_EN]      = enabled;
      end
      A_EXPCNT: bus_rdata = 32'(exp_cnt);
      default:  bus_rdata = '0;
    endcase
  end

  // R10: count frozen once the reset output is set
  a_r10_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    trip_rst |=> $stable(count));
endmodule

// File: tb/test_wdog_guard.sv
`timescale 1ns/1ps
module test_wdog_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        wdt_rst, sts_expired, sts_violation;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  wdog_guard i_wdog_guard (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst(wdt_rst), .sts_expired(sts_expired), .sts_violation(sts_violation)
  );

  localparam logic [31:0] KEY = 32'hAD21_AD21;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(3'd6, v); check("R1", "status", v, 32'h08);
    rd(3'd1, v); check("R1", "period", v, 0);
    rd(3'd2, v); check("R1", "count", v, 0);
    rd(3'd3, v); check("R1", "trip", v, 0);
    check("R1", "wdt_rst", {31'd0, wdt_rst}, 0);
  endtask

  task automatic t_locked_write();
    logic [31:0] v;
    wr(3'd1, 32'h55);
    rd(3'd1, v); check("R2", "period after locked write", v, 0);
    check("R2", "violation pin", {31'd0, sts_violation}, 1);
    wr(3'd6, 32'h0);
    rd(3'd6, v); check("R8", "write 0 keeps flag", v & 32'h2, 32'h2);
    wr(3'd6, 32'h2);
    rd(3'd6, v); check("R8", "W1C violation", v & 32'h2, 0);
  endtask

  task automatic t_wrong_key();
    logic [31:0] v;
    wr(3'd4, 32'h1234_5678);
    wr(3'd3, 32'h9);
    rd(3'd3, v); check("R3", "trip after wrong key", v, 0);
    check("R3", "violation after wrong key", {31'd0, sts_violation}, 1);
    wr(3'd6, 32'h2);
  endtask

  task automatic t_setup();
    logic [31:0] v;
    wr(3'd4, KEY);
    wr(3'd3, 32'd2);
    wr(3'd1, 32'd5);
    rd(3'd2, v); check("R4", "preloaded count", v, 5);
    ticks(3);
    rd(3'd2, v); check("R5", "no count while disabled", v, 5);
    wr(3'd5, 32'd0);
    wr(3'd0, 32'd1);
    rd(3'd0, v); check("R3", "enable blocked after relock", v, 0);
    wr(3'd4, KEY);
    wr(3'd0, 32'd1);
    wr(3'd5, 32'd0);
    rd(3'd0, v); check("R7", "enabled", v, 1);
    repeat (4) @(negedge clk);
    rd(3'd2, v); check("R5", "no count without tick", v, 5);
    ticks(1);
    rd(3'd2, v); check("R5", "one tick", v, 4);
  endtask

  task automatic t_service();
    logic [31:0] v;
    ticks(2);
    rd(3'd2, v); check("R5", "after burst", v, 2);
    wr(3'd4, KEY);
    wr(3'd1, 32'd99);
    wr(3'd3, 32'd9);
    wr(3'd0, 32'd0);
    wr(3'd5, 32'd0);
    rd(3'd1, v); check("R7", "period frozen", v, 5);
    rd(3'd2, v); check("R7", "service reload", v, 5);
    rd(3'd3, v); check("R7", "trip frozen", v, 2);
    rd(3'd0, v); check("R7", "still enabled", v, 1);
  endtask

  task automatic t_trip();
    logic [31:0] v;
    ticks(5);
    rd(3'd2, v); check("R6", "reload on expiry", v, 5);
    check("R6", "expired pin", {31'd0, sts_expired}, 1);
    rd(3'd7, v); check("R9", "expirations 1", v, 1);
    wr(3'd6, 32'h1);
    rd(3'd6, v); check("R8", "W1C expired", v & 32'h1, 0);
    ticks(5);
    rd(3'd7, v); check("R9", "expirations 2", v, 2);
    ticks(4);
    check("R9", "no reset before last", {31'd0, wdt_rst}, 0);
    ticks(1);
    check("R9", "reset on trip", {31'd0, wdt_rst}, 1);
    rd(3'd2, v);
    ticks(3);
    begin
      logic [31:0] v2;
      rd(3'd2, v2); check("R10", "count frozen", v2, v);
    end
    wr(3'd4, KEY);
    wr(3'd1, 32'd7);
    wr(3'd6, 32'h3);
    check("R10", "reset held", {31'd0, wdt_rst}, 1);
  endtask

  task automatic t_sys_reset();
    logic [31:0] v;
    sys_reset();
    check("R1", "reset released", {31'd0, wdt_rst}, 0);
    rd(3'd6, v); check("R1", "status after reset", v, 32'h08);
    rd(3'd7, v); check("R1", "expcnt after reset", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_locked_write();
    t_wrong_key();
    t_setup();
    t_service();
    t_trip();
    t_sys_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule